// File: doc/BRIEF.md
# Bit-Sliced Arithmetic Logic Unit with Signed Less-Than

This block is a purely combinational arithmetic logic unit. It is built from identical one-bit slices that are chained by a ripple carry. It takes two data operands and a three-bit operation code. It returns a data result and three flags: zero, signed overflow and carry-out. The operations are bitwise AND, bitwise OR, add, subtract and signed set-on-less-than.

Subtraction reuses the adder. One negate control comes from the top bit of the operation code. It inverts every bit of the second operand and also supplies the carry into bit 0, so the unit forms a + ~b + 1. Set-on-less-than runs the same subtraction. The most significant slice produces a compare bit. That bit is the top sum bit corrected by the subtraction overflow, so the answer stays right even when a − b wraps. The compare bit is fed back to the spare mux input of bit 0, and every higher slice sees zero on that input.

An equality test is a subtraction followed by a look at the zero flag. The block has no clock and no state.

Top module: `bitslice_alu`

## Requirements
- R1: Code 3'b000 gives the bitwise AND of a and b. Code 3'b001 gives the bitwise OR. For both, overflow and carry-out are 0.
- R2: Code 3'b010 gives a + b modulo 2^W. Carry-out is the carry leaving bit W-1.
- R3: Code 3'b110 gives a − b, formed as a + ~b + 1. Carry-out is the carry leaving bit W-1, which is 1 exactly when a ≥ b as unsigned values.
- R4: Code 3'b111 gives a result of 1 when a < b as signed two's-complement values, and 0 otherwise. Bits W-1..1 of the result are always 0. The answer is correct even when a − b overflows. Carry-out equals that of the subtraction.
- R5: The zero flag is 1 exactly when every result bit is 0. Under code 3'b110 it is therefore 1 exactly when a equals b.
- R6: Signed overflow is 1 in four cases: an add of two non-negative operands gives a negative result; an add of two negative operands gives a non-negative result; a subtraction of a negative from a non-negative gives a negative result; a subtraction of a non-negative from a negative gives a non-negative result. Under code 3'b111 the overflow flag reports the overflow of the internal subtraction.
- R7: Overflow is never 1 for an add whose operands differ in sign, or for a subtraction whose operands share a sign.
- R8: Overflow is 0 for codes 3'b000 and 3'b001, whatever the operands.
- R9: The unused codes 3'b011, 3'b100 and 3'b101 give a result of all zeros, with overflow 0, carry-out 0 and zero 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | DATA_W | First operand |
| opb_i | input | DATA_W | Second operand |
| opcode_i | input | 3 | Operation select; bit 2 is the negate control |
| result_o | output | DATA_W | Operation result |
| zero_o | output | 1 | High when every result bit is 0 |
| ovf_o | output | 1 | Signed overflow of add, subtract or compare |
| carry_o | output | 1 | Carry leaving the top slice for arithmetic codes |

## Verification
The assertions are evaluated whenever the inputs change. They check that add and subtract agree with plain arithmetic, that the upper bits of a compare result are zero, and that a subtraction raises zero exactly on equal operands. They also check that logic codes never flag overflow, that mixed-sign adds never flag overflow, and that unused codes give a zero result.

The exact signed compare outcome near the wrap points, the carry-out values and the overflow flag in all four overflow cases are only shown by the bench. It runs directed operands at maxint, minint, all ones and equal values, plus a seeded random sweep over every operation code. Each result is compared against a reference the bench computes for itself.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Operation codes; bit 2 doubles as the negate control
    typedef enum logic [2:0] {
        OP_AND  = 3'b000,
        OP_OR   = 3'b001,
        OP_ADD  = 3'b010,
        OP_SUB  = 3'b110,
        OP_SLT  = 3'b111
    } alu_op_e;

    // Per-slice result mux select
    typedef enum logic [1:0] {
        PICK_AND  = 2'b00,
        PICK_OR   = 2'b01,
        PICK_SUM  = 2'b10,
        PICK_LESS = 2'b11
    } slice_pick_e;

    typedef struct packed {
        logic       negate;
        logic [1:0] pick;
        logic       valid;
        logic       arith;
    } op_ctrl_t;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
    import alu_pkg::*;
(
    input  logic [2:0] opcode_i,
    output logic       negate_o,
    output logic [1:0] pick_o,
    output logic       valid_o,
    output logic       arith_o
);

    op_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d        = '0;
        ctrl_d.negate = opcode_i[2];
        ctrl_d.pick   = opcode_i[1:0];
        unique case (opcode_i)
            OP_AND, OP_OR: begin
                ctrl_d.valid = 1'b1;
                ctrl_d.arith = 1'b0;
            end
            OP_ADD, OP_SUB, OP_SLT: begin
                ctrl_d.valid = 1'b1;
                ctrl_d.arith = 1'b1;
            end
            default: begin
                ctrl_d.valid = 1'b0;
                ctrl_d.arith = 1'b0;
            end
        endcase
    end

    assign negate_o = ctrl_d.negate;
    assign pick_o   = ctrl_d.pick;
    assign valid_o  = ctrl_d.valid;
    assign arith_o  = ctrl_d.arith;

endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_pkg::*;
(
    input  logic       a_i,
    input  logic       b_i,
    input  logic       carry_i,
    input  logic       less_i,
    input  logic       negate_i,
    input  logic [1:0] pick_i,
    output logic       res_o,
    output logic       carry_o
);

    logic b_eff_d;
    logic sum_d;

    always_comb begin
        b_eff_d = b_i ^ negate_i;
        sum_d   = a_i ^ b_eff_d ^ carry_i;
        carry_o = (a_i & b_eff_d) | (a_i & carry_i) | (b_eff_d & carry_i);
        unique case (slice_pick_e'(pick_i))
            PICK_AND:  res_o = a_i & b_eff_d;
            PICK_OR:   res_o = a_i | b_eff_d;
            PICK_SUM:  res_o = sum_d;
            PICK_LESS: res_o = less_i;
            default:   res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu_msb_status.sv
module alu_msb_status (
    input  logic a_msb_i,
    input  logic b_msb_i,
    input  logic negate_i,
    input  logic carry_in_msb_i,
    input  logic carry_out_msb_i,
    output logic ovf_raw_o,
    output logic set_o
);

    logic sum_msb_d;

    always_comb begin
        // Signed overflow: carry into the sign slice differs from carry out
        ovf_raw_o = carry_in_msb_i ^ carry_out_msb_i;
        sum_msb_d = a_msb_i ^ (b_msb_i ^ negate_i) ^ carry_in_msb_i;
        // Sign of the true difference, corrected for wrap-around
        set_o     = sum_msb_d ^ ovf_raw_o;
    end

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [2:0]        opcode_i,
    output logic [DATA_W-1:0] result_o,
    output logic              zero_o,
    output logic              ovf_o,
    output logic              carry_o
);

    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              zero;
        logic              ovf;
        logic              carry;
    } alu_out_t;

    logic              negate_w;
    logic [1:0]        pick_w;
    logic              valid_w;
    logic              arith_w;
    logic              set_w;
    logic              ovf_raw_w;
    logic [DATA_W-1:0] res_raw_w;
    alu_out_t          out_d;

    alu_op_decode u_dec (
        .opcode_i (opcode_i),
        .negate_o (negate_w),
        .pick_o   (pick_w),
        .valid_o  (valid_w),
        .arith_o  (arith_w)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_slice
        logic cin_w;
        logic less_w;
        logic res_w;
        logic cout_w;
        if (i == 0) begin : g_lsb
            assign cin_w  = negate_w;
            assign less_w = set_w;
        end else begin : g_upper
            assign cin_w  = g_slice[i-1].cout_w;
            assign less_w = 1'b0;
        end
        alu_bit_slice u_bit (
            .a_i      (opa_i[i]),
            .b_i      (opb_i[i]),
            .carry_i  (cin_w),
            .less_i   (less_w),
            .negate_i (negate_w),
            .pick_i   (pick_w),
            .res_o    (res_w),
            .carry_o  (cout_w)
        );
        assign res_raw_w[i] = res_w;
    end

    alu_msb_status u_msb (
        .a_msb_i         (opa_i[MSB]),
        .b_msb_i         (opb_i[MSB]),
        .negate_i        (negate_w),
        .carry_in_msb_i  (g_slice[MSB].cin_w),
        .carry_out_msb_i (g_slice[MSB].cout_w),
        .ovf_raw_o       (ovf_raw_w),
        .set_o           (set_w)
    );

    always_comb begin
        out_d        = '0;
        out_d.result = valid_w ? res_raw_w : '0;
        out_d.ovf    = arith_w & ovf_raw_w;
        out_d.carry  = arith_w & g_slice[MSB].cout_w;
        out_d.zero   = ~|out_d.result;
    end

    assign result_o = out_d.result;
    assign zero_o   = out_d.zero;
    assign ovf_o    = out_d.ovf;
    assign carry_o  = out_d.carry;

    // Checks on the finished outputs against plain arithmetic
    always_comb begin
        if (opcode_i == OP_ADD)
            assert_add_sum_R2: assert (result_o == opa_i + opb_i)
                else $error("R2 add mismatch");
        if (opcode_i == OP_SUB)
            assert_sub_diff_R3: assert (result_o == opa_i - opb_i)
                else $error("R3 subtract mismatch");
        if (opcode_i == OP_SLT)
            assert_slt_upper_R4: assert (result_o[MSB:1] == '0)
                else $error("R4 compare upper bits set");
        if (opcode_i == OP_SUB)
            assert_eq_zero_R5: assert (zero_o == (opa_i == opb_i))
                else $error("R5 equality via zero flag wrong");
        if (opcode_i == OP_ADD && (opa_i[MSB] != opb_i[MSB]))
            assert_no_overflow_R7: assert (!ovf_o)
                else $error("R7 overflow on mixed-sign add");
        if (opcode_i == OP_AND || opcode_i == OP_OR)
            assert_logic_ovf_R8: assert (!ovf_o && !carry_o)
                else $error("R8 flags set on logic op");
        if (opcode_i == 3'b011 || opcode_i == 3'b100 || opcode_i == 3'b101)
            assert_unused_R9: assert (result_o == '0 && !ovf_o && zero_o)
                else $error("R9 unused code not cleared");
    end

endmodule

// File: tb/sim_bitslice_alu.sv
module sim_bitslice_alu;

    localparam int  W        = 32;
    localparam time CLK_PER  = 10ns;
    localparam int  WATCHDOG = 50000;
    localparam int  N_RAND   = 3000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b;
    logic [2:0]   op;
    logic [W-1:0] res;
    logic         zf, vf, cf;
    int           n_chk  = 0;
    int           n_fail = 0;
    int           cycles = 0;
    bit           done   = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    bitslice_alu #(.DATA_W(W)) u0 (
        .opa_i    (a),
        .opb_i    (b),
        .opcode_i (op),
        .result_o (res),
        .zero_o   (zf),
        .ovf_o    (vf),
        .carry_o  (cf)
    );

    typedef struct packed {
        logic [W-1:0] r;
        logic         z;
        logic         v;
        logic         c;
    } exp_t;

    function automatic exp_t model(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [2:0] code);
        exp_t       e;
        logic [W:0] s;
        e = '0;
        case (code)
            3'b000: e.r = x & y;
            3'b001: e.r = x | y;
            3'b010: begin
                s   = {1'b0, x} + {1'b0, y};
                e.r = s[W-1:0];
                e.c = s[W];
                e.v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
            end
            3'b110, 3'b111: begin
                s   = {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, 1'b1};
                e.c = s[W];
                e.v = (x[W-1] != y[W-1]) && (s[W-1] != x[W-1]);
                if (code == 3'b110) e.r = s[W-1:0];
                else e.r = ($signed(x) < $signed(y)) ? {{(W-1){1'b0}}, 1'b1} : '0;
            end
            default: e.r = '0;
        endcase
        e.z = (e.r == '0);
        return e;
    endfunction

    function automatic string tag_of(input logic [2:0] code);
        case (code)
            3'b000, 3'b001: return "R1";
            3'b010:         return "R2";
            3'b110:         return "R3";
            3'b111:         return "R4";
            default:        return "R9";
        endcase
    endfunction

    task automatic run(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [2:0] code, input string tag);
        exp_t e;
        @(posedge clk);
        a  = x;
        b  = y;
        op = code;
        @(negedge clk);
        e = model(x, y, code);
        n_chk++;
        if ({res, zf, vf, cf} !== {e.r, e.z, e.v, e.c}) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h actual r=%h z=%b v=%b c=%b expected r=%h z=%b v=%b c=%b",
                     tag, code, x, y, res, zf, vf, cf, e.r, e.z, e.v, e.c);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [W-1:0] x, y;
        logic [2:0]   code;
        a  = '0;
        b  = '0;
        op = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // Reset state: zero inputs with AND give zero result and flags (R1, R5)
        n_chk++;
        if ({res, zf, vf, cf} !== {{W{1'b0}}, 1'b1, 1'b0, 1'b0}) begin
            n_fail++;
            $display("FAIL R1 reset actual r=%h z=%b v=%b c=%b expected r=0 z=1 v=0 c=0",
                     res, zf, vf, cf);
        end
        rst = 1'b0;

        // Directed corner cases
        run(32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000, "R1");
        run(32'hF0F0_1234, 32'h0FF0_0000, 3'b001, "R1");
        run(32'h7FFF_FFFF, 32'h0000_0001, 3'b010, "R6");  // R6 pos+pos -> neg
        run(32'h8000_0000, 32'h8000_0000, 3'b010, "R6");  // R6 neg+neg wraps, carry out
        run(32'hFFFF_FFFF, 32'h0000_0001, 3'b010, "R2");  // R2 carry, zero result (R5)
        run(32'h8000_0000, 32'h0000_0001, 3'b110, "R6");  // R6 neg-pos -> pos
        run(32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110, "R6");  // R6 pos-neg -> neg
        run(32'h1234_5678, 32'h1234_5678, 3'b110, "R5");  // R5 equal operands
        run(32'h0000_0003, 32'h0000_0005, 3'b110, "R3");  // R3 borrow, carry 0
        run(32'hFFFF_FFF0, 32'h0000_0010, 3'b010, "R7");  // R7 mixed-sign add
        run(32'h8000_0000, 32'hFFFF_FFFF, 3'b110, "R7");  // R7 same-sign sub
        run(32'h8000_0000, 32'h0000_0001, 3'b111, "R4");  // R4 minint < 1 with wrap
        run(32'h7FFF_FFFF, 32'h8000_0000, 3'b111, "R4");  // R4 maxint > minint
        run(32'h8000_0000, 32'h7FFF_FFFF, 3'b111, "R4");
        run(32'h0000_0009, 32'h0000_0009, 3'b111, "R4");
        run(32'hFFFF_FFFF, 32'h0000_0000, 3'b111, "R4");
        run(32'h7FFF_FFFF, 32'h7FFF_FFFF, 3'b000, "R8");  // R8 no overflow on logic
        run(32'h8000_0000, 32'h8000_0000, 3'b001, "R8");
        run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, "R9");
        run(32'h7FFF_FFFF, 32'h0000_0001, 3'b100, "R9");
        run(32'h8000_0000, 32'h0000_0001, 3'b101, "R9");

        // Seeded random sweep over all codes
        seed = $urandom(32'd2024);
        for (int k = 0; k < N_RAND; k++) begin
            x    = $urandom;
            y    = $urandom;
            code = 3'($urandom);
            if (k % 7 == 0) y = x;
            if (k % 11 == 0) x[W-1] = ~y[W-1];
            run(x, y, code, tag_of(code));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule